// File: doc/BRIEF.md
# Magnitude Peak Finder with Signed Angle Bin

This block watches a stream of complex spectrum samples, one per clock when `s_valid` is high, and reports the sample with the largest magnitude in each frame. The sample flagged with `s_last` closes the frame. Magnitudes are compared as the sum of squares of the real and imaginary parts. Squaring keeps the same ordering as the true magnitude and needs no square root.

In map mode (`mode_angle` = 0) the frame is a two-dimensional range-velocity map sent row by row. The sample position is split into a row and a column using the configured column count. The winning row is the range bin and the winning column is the velocity bin.

In angle mode (`mode_angle` = 1) the frame is a 32-point angle spectrum taken at one range-velocity cell. The winning bin is folded into a signed angle bin. The lower half of the spectrum holds angles from 0 up to +90 degrees and the upper half holds angles from -90 up to 0. Together they cover the whole field from -90 to +90 degrees.

The control is a three-state machine:
- `ST_IDLE`: no frame seen since reset.
- `ST_SCAN`: a frame is in progress.
- `ST_DONE`: a result is held.

Its transitions are:
- *open* (IDLE→SCAN, or DONE→SCAN): a sample is accepted without `s_last`.
- *close* (SCAN→DONE): a sample is accepted with `s_last`.
- *single* (IDLE→DONE, or DONE→DONE): a one-sample frame, where the first sample of the frame also carries `s_last`.

Top module: `mag_peak_finder`

## Requirements
- R1: The magnitude of each sample is re*re + im*im, where re and im are signed two's-complement values. `peak_mag` reports this value for the winning sample.
- R2: The winning sample is the one with the largest magnitude. When magnitudes are equal, the earliest sample in the frame wins, because a later sample replaces the winner only when it is strictly greater.
- R3: In map mode, sample number i of a frame (counting from 0) has column i mod C and row i div C, where C is the column count. `peak_row` is the range bin and `peak_col` is the velocity bin.
- R4: In angle mode the column count is ignored. Sample k has `peak_col` = k and `peak_row` = 0 for k from 0 to 31. `angle_bin` is a 6-bit two's-complement value equal to k when k < 16 and k - 32 when k >= 16.
- R5: `res_valid` goes high in the cycle after the clock edge that accepts the `s_last` sample. The result outputs take their new values at that same edge.
- R6: While no sample is accepted, `res_valid` and all result outputs stay unchanged. Accepting the first sample of a new frame without `s_last` drops `res_valid`. The result outputs keep their old values until that frame closes.
- R7: After reset every output is 0. A frame with no samples causes nothing: `res_valid` stays low while `s_valid` is low.
- R8: The mode and the column count are taken from the inputs when the first sample of a frame is accepted. Changes to them later in the same frame have no effect on that frame's result.
- R9: A one-sample frame produces a valid result with row 0 and column 0 and that sample's magnitude. This holds even when the previous result is still being held.
- R10: In map mode `angle_bin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_angle | input | 1 | 0 = range-velocity map, 1 = angle spectrum; sampled at frame start |
| num_cols | input | COL_W | Columns per row in map mode; sampled at frame start |
| s_valid | input | 1 | Sample present this cycle |
| s_re | input | SAMPLE_W | Real part, signed |
| s_im | input | SAMPLE_W | Imaginary part, signed |
| s_last | input | 1 | Marks the final sample of the frame |
| res_valid | output | 1 | A result is held |
| peak_mag | output | 2*SAMPLE_W | Squared magnitude of the winner |
| peak_row | output | ROW_W | Row of the winner (range bin) |
| peak_col | output | COL_W | Column of the winner (velocity bin, or angle spectrum bin) |
| angle_bin | output | ANG_W+1 | Signed angle bin of the winner in angle mode, else 0 |

## Verification
The bench builds the block with 8-bit samples, a 4-bit row field and a 5-bit column field. The angle spectrum keeps its 32 points.

This small configuration makes it possible to sweep every column count from 1 to 8 against every row count from 1 to 4. It also lets the bench place the peak of the angle spectrum at each of the 32 bins in turn. Because of this, every row and column wrap and every fold of the angle halves is compared with a value the bench works out itself.

With 8-bit samples the extreme values such as -128 are easy to drive, so the squared sum can be checked near its upper limit. Tie frames, one-sample frames and a mode change in the middle of a frame are also run.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } mpf_state_e;

    typedef enum logic {
        MODE_MAP   = 1'b0,
        MODE_ANGLE = 1'b1
    } mpf_mode_e;

endpackage

// File: rtl/mpf_mag_sq.sv
module mpf_mag_sq #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0]   re,
    input  logic signed [SAMPLE_W-1:0]   im,
    output logic        [2*SAMPLE_W-1:0] mag
);
    localparam int PROD_W = 2 * SAMPLE_W;

    logic signed [PROD_W-1:0] re_ext;
    logic signed [PROD_W-1:0] im_ext;
    logic signed [PROD_W-1:0] re_sq;
    logic signed [PROD_W-1:0] im_sq;

    always_comb begin
        re_ext = PROD_W'(re);
        im_ext = PROD_W'(im);
        re_sq  = re_ext * re_ext;
        im_sq  = im_ext * im_ext;
        mag    = $unsigned(re_sq) + $unsigned(im_sq);
    end
endmodule

// File: rtl/mpf_index_track.sv
module mpf_index_track #(
    parameter int ROW_W = 10,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             start,
    input  logic [COL_W-1:0] limit,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col
);
    logic [ROW_W-1:0] nxt_row_q;
    logic [COL_W-1:0] nxt_col_q;
    logic             wrap;

    always_comb begin
        cur_row = start ? '0 : nxt_row_q;
        cur_col = start ? '0 : nxt_col_q;
        wrap    = (cur_col == limit - COL_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_row_q <= '0;
            nxt_col_q <= '0;
        end else if (step) begin
            if (wrap) begin
                nxt_col_q <= '0;
                nxt_row_q <= cur_row + ROW_W'(1);
            end else begin
                nxt_col_q <= cur_col + COL_W'(1);
                nxt_row_q <= cur_row;
            end
        end
    end
endmodule

// File: rtl/mpf_best_hold.sv
module mpf_best_hold #(
    parameter int MAG_W = 32,
    parameter int ROW_W = 10,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             start,
    input  logic [MAG_W-1:0] mag,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [MAG_W-1:0] win_mag,
    output logic [ROW_W-1:0] win_row,
    output logic [COL_W-1:0] win_col
);
    logic [MAG_W-1:0] best_mag_q;
    logic [ROW_W-1:0] best_row_q;
    logic [COL_W-1:0] best_col_q;
    logic             take;

    always_comb begin
        take    = start || (mag > best_mag_q);
        win_mag = take ? mag : best_mag_q;
        win_row = take ? row : best_row_q;
        win_col = take ? col : best_col_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_mag_q <= '0;
            best_row_q <= '0;
            best_col_q <= '0;
        end else if (step) begin
            best_mag_q <= win_mag;
            best_row_q <= win_row;
            best_col_q <= win_col;
        end
    end
endmodule

// File: rtl/mag_peak_finder.sv
module mag_peak_finder
    import mpf_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ROW_W    = 10,
    parameter int COL_W    = 8,
    parameter int ANG_PTS  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_angle,
    input  logic [COL_W-1:0]            num_cols,
    input  logic                        s_valid,
    input  logic signed [SAMPLE_W-1:0]  s_re,
    input  logic signed [SAMPLE_W-1:0]  s_im,
    input  logic                        s_last,
    output logic                        res_valid,
    output logic [2*SAMPLE_W-1:0]       peak_mag,
    output logic [ROW_W-1:0]            peak_row,
    output logic [COL_W-1:0]            peak_col,
    output logic signed [$clog2(ANG_PTS):0] angle_bin
);
    localparam int MAG_W  = 2 * SAMPLE_W;
    localparam int ANG_W  = $clog2(ANG_PTS);
    localparam int HALF   = ANG_PTS / 2;

    mpf_state_e       state_q, state_d;
    mpf_mode_e        mode_q, mode_eff, res_mode_q;
    logic [COL_W-1:0] cols_q, cols_eff, limit, res_cols_q;
    logic             start, step, close;

    logic [MAG_W-1:0] cur_mag, win_mag;
    logic [ROW_W-1:0] cur_row, win_row;
    logic [COL_W-1:0] cur_col, win_col;

    logic [MAG_W-1:0]  mag_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic signed [ANG_W:0] ang_q, ang_fold;

    // frame control and next state
    always_comb begin
        start    = (state_q != ST_SCAN);
        step     = s_valid;
        close    = s_valid && s_last;
        mode_eff = start ? mpf_mode_e'(mode_angle) : mode_q;
        cols_eff = start ? num_cols : cols_q;
        limit    = (mode_eff == MODE_ANGLE) ? COL_W'(ANG_PTS) : cols_eff;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (s_valid) state_d = s_last ? ST_DONE : ST_SCAN;
            ST_SCAN: if (close)   state_d = ST_DONE;
            ST_DONE: if (s_valid) state_d = s_last ? ST_DONE : ST_SCAN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    mpf_mag_sq #(.SAMPLE_W(SAMPLE_W)) mag_i (
        .re (s_re),
        .im (s_im),
        .mag(cur_mag)
    );

    mpf_index_track #(.ROW_W(ROW_W), .COL_W(COL_W)) idx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .start  (start),
        .limit  (limit),
        .cur_row(cur_row),
        .cur_col(cur_col)
    );

    mpf_best_hold #(.MAG_W(MAG_W), .ROW_W(ROW_W), .COL_W(COL_W)) best_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .start  (start),
        .mag    (cur_mag),
        .row    (cur_row),
        .col    (cur_col),
        .win_mag(win_mag),
        .win_row(win_row),
        .win_col(win_col)
    );

    // fold the spectrum halves into a signed bin
    always_comb begin
        ang_fold = $signed({1'b0, win_col[ANG_W-1:0]});
        if (win_col[ANG_W-1:0] >= ANG_W'(HALF))
            ang_fold = ang_fold - (ANG_W+1)'(ANG_PTS);
        if (mode_eff == MODE_MAP)
            ang_fold = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_MAP;
            cols_q     <= '0;
            res_mode_q <= MODE_MAP;
            res_cols_q <= '0;
            mag_q      <= '0;
            row_q      <= '0;
            col_q      <= '0;
            ang_q      <= '0;
        end else begin
            if (step && start) begin
                mode_q <= mode_eff;
                cols_q <= cols_eff;
            end
            if (close) begin
                res_mode_q <= mode_eff;
                res_cols_q <= cols_eff;
                mag_q      <= win_mag;
                row_q      <= win_row;
                col_q      <= win_col;
                ang_q      <= ang_fold;
            end
        end
    end

    // outputs
    always_comb begin
        res_valid = (state_q == ST_DONE);
        peak_mag  = mag_q;
        peak_row  = row_q;
        peak_col  = col_q;
        angle_bin = ang_q;
    end
endmodule

// File: rtl/mpf_chk.sv
module mpf_chk #(
    parameter int SAMPLE_W = 16,
    parameter int COL_W    = 8,
    parameter int ANG_PTS  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        s_valid,
    input logic                        s_last,
    input logic                        res_valid,
    input logic [2*SAMPLE_W-1:0]       peak_mag,
    input logic [COL_W-1:0]            peak_col,
    input logic signed [$clog2(ANG_PTS):0] angle_bin,
    input logic [2*SAMPLE_W-1:0]       cur_mag,
    input logic                        res_mode,
    input logic [COL_W-1:0]            res_cols
);
    localparam int ANG_W = $clog2(ANG_PTS);

    // R5
    valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(s_valid && s_last));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !s_valid) |=> (res_valid && $stable(peak_mag) && $stable(peak_col)));

    // R6
    reopen_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_last) |=> !res_valid);

    // R2
    peak_not_below_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_last) |=> (peak_mag >= $past(cur_mag)));

    // R4
    angle_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mode) |-> (angle_bin[ANG_W] == (peak_col >= COL_W'(ANG_PTS/2))));

    // R3
    col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_mode && res_cols != '0) |-> (peak_col < res_cols));
endmodule

bind mag_peak_finder mpf_chk #(
    .SAMPLE_W(SAMPLE_W),
    .COL_W   (COL_W),
    .ANG_PTS (ANG_PTS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .res_valid(res_valid),
    .peak_mag (peak_mag),
    .peak_col (peak_col),
    .angle_bin(angle_bin),
    .cur_mag  (cur_mag),
    .res_mode (res_mode_q),
    .res_cols (res_cols_q)
);

// File: tb/mag_peak_finder_tb_top.sv
module mag_peak_finder_tb_top;
    localparam int SW = 8;
    localparam int RW = 4;
    localparam int CW = 5;
    localparam int AP = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_angle = 1'b0;
    logic [CW-1:0] num_cols = '0;
    logic s_valid = 1'b0;
    logic signed [SW-1:0] s_re = '0;
    logic signed [SW-1:0] s_im = '0;
    logic s_last = 1'b0;
    logic res_valid;
    logic [2*SW-1:0] peak_mag;
    logic [RW-1:0] peak_row;
    logic [CW-1:0] peak_col;
    logic signed [5:0] angle_bin;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int fr_re [0:63];
    int fr_im [0:63];

    always #10 clk = ~clk;

    mag_peak_finder #(.SAMPLE_W(SW), .ROW_W(RW), .COL_W(CW), .ANG_PTS(AP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_angle(mode_angle), .num_cols(num_cols),
        .s_valid(s_valid), .s_re(s_re), .s_im(s_im), .s_last(s_last),
        .res_valid(res_valid), .peak_mag(peak_mag), .peak_row(peak_row),
        .peak_col(peak_col), .angle_bin(angle_bin)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int re, input int im, input bit last);
        s_valid = 1'b1;
        s_re    = SW'(re);
        s_im    = SW'(im);
        s_last  = last;
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    // sends fr_* [0..n-1] and checks the result against a bench model
    task automatic run_frame(input int n, input bit ang, input int cols, input string req);
        int best = -1;
        int bidx = 0;
        int m;
        int er, ec, ea;
        mode_angle = ang;
        num_cols   = CW'(cols);
        for (int i = 0; i < n; i++) begin
            m = fr_re[i] * fr_re[i] + fr_im[i] * fr_im[i];
            if (m > best) begin best = m; bidx = i; end
            send(fr_re[i], fr_im[i], i == n - 1);
        end
        if (ang) begin er = 0; ec = bidx; ea = (bidx < AP/2) ? bidx : bidx - AP; end
        else     begin er = bidx / cols; ec = bidx % cols; ea = 0; end
        chk(res_valid == 1'b1, {req, " R5 valid"}, res_valid, 1);
        chk(peak_mag == (2*SW)'(best), {req, " R1 mag"}, peak_mag, best);
        chk(peak_row == RW'(er), {req, " R3 row"}, peak_row, er);
        chk(peak_col == CW'(ec), {req, " R2 col"}, peak_col, ec);
        chk(int'(angle_bin) == ea, {req, " R4/R10 angle"}, angle_bin, ea);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(res_valid == 0 && peak_mag == 0 && peak_row == 0 && peak_col == 0 && angle_bin == 0,
            "R7 reset outputs", res_valid, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R7: zero-sample frame
        chk(res_valid == 0, "R7 no samples", res_valid, 0);

        // R3 sweep over column and row counts
        for (int c = 1; c <= 8; c++) begin
            for (int r = 1; r <= 4; r++) begin
                for (int i = 0; i < c * r; i++) begin
                    fr_re[i] = ((i * 37 + c * 11 + r * 5) % 200) - 100;
                    fr_im[i] = ((i * 53 + c * 7 + r * 3) % 180) - 90;
                end
                run_frame(c * r, 1'b0, c, "R3 map sweep");
                @(negedge clk);
            end
        end

        // R1 extreme values
        for (int i = 0; i < 6; i++) begin fr_re[i] = 3; fr_im[i] = -2; end
        fr_re[4] = -128; fr_im[4] = -128;
        run_frame(6, 1'b0, 3, "R1 extreme");

        // R2 ties: all equal -> index 0; equal peaks at 2 and 5 -> 2
        for (int i = 0; i < 8; i++) begin fr_re[i] = 5; fr_im[i] = -5; end
        run_frame(8, 1'b0, 4, "R2 all equal");
        for (int i = 0; i < 8; i++) begin fr_re[i] = 1; fr_im[i] = 1; end
        fr_re[2] = 40; fr_im[2] = 0; fr_re[5] = 0; fr_im[5] = -40;
        run_frame(8, 1'b0, 4, "R2 tie earliest");

        // R4 angle sweep: peak at every bin
        for (int p = 0; p < AP; p++) begin
            for (int i = 0; i < AP; i++) begin fr_re[i] = (i % 7) - 3; fr_im[i] = (i % 5) - 2; end
            fr_re[p] = 100; fr_im[p] = -60 + p;
            run_frame(AP, 1'b1, 3, "R4 angle sweep");
        end

        // R6 hold while idle, then drop on reopen
        begin
            logic [2*SW-1:0] held_mag;
            logic [CW-1:0] held_col;
            held_mag = peak_mag;
            held_col = peak_col;
            repeat (6) @(negedge clk);
            chk(res_valid == 1 && peak_mag == held_mag && peak_col == held_col,
                "R6 hold idle", peak_mag, held_mag);
            mode_angle = 1'b0; num_cols = CW'(4);
            send(1, 1, 1'b0);
            chk(res_valid == 0, "R6 drop on reopen", res_valid, 0);
            chk(peak_mag == held_mag, "R6 old value kept", peak_mag, held_mag);
            send(2, 2, 1'b1);
            chk(res_valid == 1 && peak_mag == 8 && peak_col == 1, "R6 new close", peak_mag, 8);
        end

        // R8 mode and columns changed mid-frame
        mode_angle = 1'b0; num_cols = CW'(3);
        send(1, 0, 1'b0);
        mode_angle = 1'b1; num_cols = CW'(7);
        for (int i = 1; i < 9; i++) send((i == 7) ? 50 : 1, 0, i == 8);
        chk(peak_row == 2 && peak_col == 1, "R8 row/col", {peak_row, peak_col}, {4'd2, 5'd1});
        chk(angle_bin == 0, "R8 mode kept", angle_bin, 0);

        // R9 one-sample frames, back to back while a result is held
        mode_angle = 1'b0; num_cols = CW'(4);
        send(7, -9, 1'b1);
        chk(res_valid == 1 && peak_mag == 130 && peak_row == 0 && peak_col == 0,
            "R9 single", peak_mag, 130);
        send(-3, 4, 1'b1);
        chk(res_valid == 1 && peak_mag == 25 && peak_col == 0, "R9 single again", peak_mag, 25);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule